// File: doc/BRIEF.md
# Byte-Packed Block Transfer Sequencer

This block sits between a 16-bit word FIFO and a byte-wide card data path. It moves one data transfer, made of a programmable number of equal blocks, in either direction. When reading from the card, it gathers incoming bytes in pairs and pushes each pair into the FIFO as one word. When writing to the card, it pops words and sends their two bytes one at a time. It keeps a count of the bytes left in the current block and of the blocks left in the transfer. Both counts can be read back at any time.

Software programs a block length and a block count, each as an 11-bit field holding the value minus one. It then issues a start strobe with a direction. The start strobe empties the FIFO, latches the direction and raises the active flag. If a block has an odd length, its last word carries a single byte. At the end of every block the byte count reloads. At the end of the transfer the block count reloads, the active flag drops and a one-cycle done pulse is produced. A new transfer of the same shape can therefore start without reprogramming.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, active_o and done_o are low, byte_left_o and blk_left_o both read 1, and card_rx_ready_o, card_tx_valid_o, fifo_push_o and fifo_pop_o are low.
- R2: Writing the length field L loads the block length L+1 and sets byte_left_o to L+1. Writing the count field N sets blk_left_o to N+1.
- R3: In the read direction (start_rd_i = 1), each pushed word holds the earlier byte in bits 7:0 and the later byte in bits 15:8, and exactly one push occurs per word.
- R4: When a block ends on an odd byte, the word holding that byte carries it in bits 7:0, with bits 15:8 zero in the read direction and the upper byte discarded in the write direction. The next byte starts a fresh word.
- R5: In the write direction (start_rd_i = 0), each popped word is sent as its bits 7:0 first and then its bits 15:8, with one pop per word.
- R6: A byte exchanged while byte_left_o is 1 reloads byte_left_o with the block length and decrements blk_left_o.
- R7: On the final byte of the final block, blk_left_o reloads with the block count, active_o falls, and done_o is high for exactly one cycle, the cycle after that byte.
- R8: In the read direction, no new word is begun while fifo_level_i exceeds fifo_afull_thr_i. A word already half built completes as long as the FIFO is not full.
- R9: In the write direction, no pop occurs and card_tx_valid_o stays low while fifo_empty_i is high.
- R10: Writing the count field also reloads byte_left_o from the block length.
- R11: A start strobe asserts fifo_flush_o in the same cycle, latches the direction, sets active_o and discards any half-built word.
- R12: At most one byte moves per cycle, and only in the latched direction: card_rx_ready_o is never high in the write direction, and card_tx_valid_o is never high in the read direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_we_i | input | 1 | Write strobe for the block-length field |
| cfg_len_i | input | 11 | Block length minus one |
| cfg_cnt_we_i | input | 1 | Write strobe for the block-count field |
| cfg_cnt_i | input | 11 | Block count minus one |
| start_i | input | 1 | Starts a data transfer |
| start_rd_i | input | 1 | Direction with start: 1 card to FIFO, 0 FIFO to card |
| fifo_level_i | input | 6 | FIFO fill level in words |
| fifo_afull_thr_i | input | 5 | Almost-full threshold in words |
| fifo_full_i | input | 1 | FIFO full |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_flush_o | output | 1 | Empties the FIFO |
| fifo_push_o | output | 1 | Pushes fifo_wdata_o |
| fifo_wdata_o | output | 16 | Packed word to the FIFO |
| fifo_pop_o | output | 1 | Pops the head word |
| fifo_rdata_i | input | 16 | Head word of the FIFO (show-ahead) |
| card_rx_valid_i | input | 1 | Card offers a byte |
| card_rx_data_i | input | 8 | Byte from the card |
| card_rx_ready_o | output | 1 | Sequencer takes the offered byte |
| card_tx_valid_o | output | 1 | Sequencer offers a byte |
| card_tx_data_o | output | 8 | Byte to the card |
| card_tx_ready_i | input | 1 | Card takes the offered byte |
| byte_left_o | output | 12 | Bytes left in the current block |
| blk_left_o | output | 12 | Blocks left in the transfer |
| active_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The hardest condition to reach is the read-direction pause with the FIFO sitting just above its almost-full threshold. The card must keep offering bytes while the pause holds, and the transfer must resume exactly one word at a time as space frees up. The bench lowers the threshold to one word and leaves the FIFO unread so that filling stalls after two words. It then pops a single word and checks that exactly one more word enters before the next stall. A restart with a half-built word, and blocks one byte long, are driven on purpose to reach the odd-tail and discard paths.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_dir_e;

  function automatic int cnt_width(input int len_w);
    return len_w + 1;
  endfunction

endpackage

// File: rtl/bxs_counters.sv
module bxs_counters #(
  parameter int LEN_W = 11,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             cnt_we_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic             fire_i,
  output logic             last_byte_o,
  output logic             xfer_end_o,
  output logic [CNT_W-1:0] byte_left_o,
  output logic [CNT_W-1:0] blk_left_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] blen_q, blen_d;
  logic [CNT_W-1:0] nblk_q, nblk_d;
  logic [CNT_W-1:0] byte_q, byte_d;
  logic [CNT_W-1:0] blk_q,  blk_d;

  always_comb begin
    blen_d     = blen_q;
    nblk_d     = nblk_q;
    byte_d     = byte_q;
    blk_d      = blk_q;
    xfer_end_o = 1'b0;
    if (len_we_i) begin
      blen_d = CNT_W'(len_i) + ONE;
      byte_d = blen_d;
    end
    if (cnt_we_i) begin
      nblk_d = CNT_W'(cnt_i) + ONE;
      blk_d  = nblk_d;
      byte_d = blen_d;
    end
    if (fire_i && !len_we_i && !cnt_we_i) begin
      if (byte_q == ONE) begin
        byte_d = blen_q;
        if (blk_q == ONE) begin
          blk_d      = nblk_q;
          xfer_end_o = 1'b1;
        end else begin
          blk_d = blk_q - ONE;
        end
      end else begin
        byte_d = byte_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= ONE;
      nblk_q <= ONE;
      byte_q <= ONE;
      blk_q  <= ONE;
    end else begin
      blen_q <= blen_d;
      nblk_q <= nblk_d;
      byte_q <= byte_d;
      blk_q  <= blk_d;
    end
  end

  assign last_byte_o = (byte_q == ONE);
  assign byte_left_o = byte_q;
  assign blk_left_o  = blk_q;

endmodule

// File: rtl/bxs_rx_pack.sv
module bxs_rx_pack #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              last_byte_i,
  input  logic              fifo_over_i,
  input  logic              fifo_full_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              fire_o,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o
);

  logic              have_low_q, have_low_d;
  logic [BYTE_W-1:0] low_q, low_d;
  logic              low_en;

  always_comb begin
    if (have_low_q) rx_ready_o = en_i && !clr_i && !fifo_full_i;
    else            rx_ready_o = en_i && !clr_i && !fifo_full_i && !fifo_over_i;
    fire_o      = rx_ready_o && rx_valid_i;
    push_o      = fire_o && (have_low_q || last_byte_i);
    push_data_o = have_low_q ? {rx_data_i, low_q} : {{BYTE_W{1'b0}}, rx_data_i};
  end

  always_comb begin
    have_low_d = have_low_q;
    low_en     = 1'b0;
    low_d      = rx_data_i;
    if (clr_i) begin
      have_low_d = 1'b0;
    end else if (push_o) begin
      have_low_d = 1'b0;
    end else if (fire_o) begin
      have_low_d = 1'b1;
      low_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_low_q <= 1'b0;
      low_q      <= '0;
    end else begin
      have_low_q <= have_low_d;
      if (low_en) low_q <= low_d;
    end
  end

endmodule

// File: rtl/bxs_tx_unpack.sv
module bxs_tx_unpack #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              last_byte_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] pop_data_i,
  input  logic              tx_ready_i,
  output logic              pop_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              fire_o
);

  logic              held_q, held_d;
  logic              hi_q, hi_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;

  always_comb begin
    pop_o      = en_i && !clr_i && !held_q && !fifo_empty_i;
    tx_valid_o = en_i && !clr_i && held_q;
    tx_data_o  = hi_q ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];
    fire_o     = tx_valid_o && tx_ready_i;
  end

  always_comb begin
    held_d  = held_q;
    hi_d    = hi_q;
    word_en = 1'b0;
    if (clr_i) begin
      held_d = 1'b0;
      hi_d   = 1'b0;
    end else if (pop_o) begin
      held_d  = 1'b1;
      hi_d    = 1'b0;
      word_en = 1'b1;
    end else if (fire_o) begin
      if (!hi_q && !last_byte_i) begin
        hi_d = 1'b1;
      end else begin
        held_d = 1'b0;
        hi_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hi_q   <= 1'b0;
      word_q <= '0;
    end else begin
      held_q <= held_d;
      hi_q   <= hi_d;
      if (word_en) word_q <= pop_data_i;
    end
  end

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int BYTE_W = 8,
  parameter int LVL_W  = 6,
  localparam int CNT_W  = cnt_width(LEN_W),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_len_we_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_cnt_we_i,
  input  logic [LEN_W-1:0]  cfg_cnt_i,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [LVL_W-2:0]  fifo_afull_thr_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  output logic              fifo_flush_o,
  output logic              fifo_push_o,
  output logic [WORD_W-1:0] fifo_wdata_o,
  output logic              fifo_pop_o,
  input  logic [WORD_W-1:0] fifo_rdata_i,
  input  logic              card_rx_valid_i,
  input  logic [BYTE_W-1:0] card_rx_data_i,
  output logic              card_rx_ready_o,
  output logic              card_tx_valid_o,
  output logic [BYTE_W-1:0] card_tx_data_o,
  input  logic              card_tx_ready_i,
  output logic [CNT_W-1:0]  byte_left_o,
  output logic [CNT_W-1:0]  blk_left_o,
  output logic              active_o,
  output logic              done_o
);

  logic      rst_meta_q, rst_sync_n;
  logic      active_q, active_d;
  xfer_dir_e dir_q, dir_d;
  logic      done_q;
  logic      last_byte, xfer_end;
  logic      rx_fire, tx_fire, byte_fire;
  logic      fifo_over;
  logic      rd_en, wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign fifo_over = fifo_level_i > LVL_W'(fifo_afull_thr_i);
  assign rd_en     = active_q && (dir_q == XFER_RD);
  assign wr_en     = active_q && (dir_q == XFER_WR);
  assign byte_fire = rx_fire || tx_fire;

  always_comb begin
    active_d = active_q;
    dir_d    = dir_q;
    if (start_i) begin
      active_d = 1'b1;
      dir_d    = start_rd_i ? XFER_RD : XFER_WR;
    end else if (xfer_end) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      active_q <= 1'b0;
      dir_q    <= XFER_WR;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      dir_q    <= dir_d;
      done_q   <= xfer_end && !start_i;
    end
  end

  bxs_counters #(.LEN_W(LEN_W)) i_counters (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .len_we_i    (cfg_len_we_i),
    .len_i       (cfg_len_i),
    .cnt_we_i    (cfg_cnt_we_i),
    .cnt_i       (cfg_cnt_i),
    .fire_i      (byte_fire),
    .last_byte_o (last_byte),
    .xfer_end_o  (xfer_end),
    .byte_left_o (byte_left_o),
    .blk_left_o  (blk_left_o)
  );

  bxs_rx_pack #(.BYTE_W(BYTE_W)) i_rx_pack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr_i       (start_i),
    .en_i        (rd_en),
    .last_byte_i (last_byte),
    .fifo_over_i (fifo_over),
    .fifo_full_i (fifo_full_i),
    .rx_valid_i  (card_rx_valid_i),
    .rx_data_i   (card_rx_data_i),
    .rx_ready_o  (card_rx_ready_o),
    .fire_o      (rx_fire),
    .push_o      (fifo_push_o),
    .push_data_o (fifo_wdata_o)
  );

  bxs_tx_unpack #(.BYTE_W(BYTE_W)) i_tx_unpack (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clr_i        (start_i),
    .en_i         (wr_en),
    .last_byte_i  (last_byte),
    .fifo_empty_i (fifo_empty_i),
    .pop_data_i   (fifo_rdata_i),
    .tx_ready_i   (card_tx_ready_i),
    .pop_o        (fifo_pop_o),
    .tx_valid_o   (card_tx_valid_o),
    .tx_data_o    (card_tx_data_o),
    .fire_o       (tx_fire)
  );

  assign fifo_flush_o = start_i;
  assign active_o     = active_q;
  assign done_o       = done_q;

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             active_o,
  input logic             done_o,
  input logic             card_rx_ready_o,
  input logic             card_tx_valid_o,
  input logic             fifo_push_o,
  input logic             fifo_pop_o,
  input logic             fifo_full_i,
  input logic             fifo_empty_i,
  input logic [CNT_W-1:0] byte_left_o,
  input logic [CNT_W-1:0] blk_left_o
);

  a_r12_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_rx_ready_o && card_tx_valid_o));

  a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> !fifo_empty_i);

  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push_o |-> !fifo_full_i);

  a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_o);

  a_r1_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !(card_rx_ready_o || card_tx_valid_o || fifo_push_o || fifo_pop_o));

  a_r11_start_activates: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o);

  a_r6_counts_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_left_o != '0) && (blk_left_o != '0));

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .start_i         (start_i),
  .active_o        (active_o),
  .done_o          (done_o),
  .card_rx_ready_o (card_rx_ready_o),
  .card_tx_valid_o (card_tx_valid_o),
  .fifo_push_o     (fifo_push_o),
  .fifo_pop_o      (fifo_pop_o),
  .fifo_full_i     (fifo_full_i),
  .fifo_empty_i    (fifo_empty_i),
  .byte_left_o     (byte_left_o),
  .blk_left_o      (blk_left_o)
);

// File: tb/test_blk_xfer_seq.sv
`timescale 1ns/1ps
module test_blk_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_len_we, cfg_cnt_we;
  logic [10:0] cfg_len, cfg_cnt;
  logic        start, start_rd;
  logic [4:0]  afull_thr;
  logic        flush, dut_push, dut_pop;
  logic [15:0] wdata;
  logic        rx_ready, tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic [11:0] byte_left, blk_left;
  logic        active, done;

  // bench FIFO model (show-ahead, 32 words)
  logic [15:0] fmem [0:31];
  logic [4:0]  frp = 5'd0, fwp = 5'd0;
  logic [5:0]  fcnt = 6'd0;
  logic        tb_push, tb_pop;
  logic [15:0] tb_pdata;

  // card source and logs
  logic [7:0]  rx_bytes [0:127];
  int          rx_idx = 0, rx_lim = 0, rx_tail = 0;
  logic [15:0] push_log [0:127];
  logic [7:0]  tx_log [0:127];
  int          npush = 0, npop = 0, ntx = 0, done_cnt = 0;
  logic        tx_stall_en;
  int          ncyc = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wire rx_valid = rx_idx < rx_lim;
  wire [7:0] rx_data = rx_bytes[rx_idx[6:0]];

  blk_xfer_seq i_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_len_we_i(cfg_len_we), .cfg_len_i(cfg_len),
    .cfg_cnt_we_i(cfg_cnt_we), .cfg_cnt_i(cfg_cnt),
    .start_i(start), .start_rd_i(start_rd),
    .fifo_level_i(fcnt), .fifo_afull_thr_i(afull_thr),
    .fifo_full_i(fcnt == 6'd32), .fifo_empty_i(fcnt == 6'd0),
    .fifo_flush_o(flush), .fifo_push_o(dut_push), .fifo_wdata_o(wdata),
    .fifo_pop_o(dut_pop), .fifo_rdata_i(fmem[frp]),
    .card_rx_valid_i(rx_valid), .card_rx_data_i(rx_data), .card_rx_ready_o(rx_ready),
    .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data), .card_tx_ready_i(tx_ready),
    .byte_left_o(byte_left), .blk_left_o(blk_left),
    .active_o(active), .done_o(done)
  );

  always @(posedge clk) begin
    if (flush) begin
      frp <= 5'd0; fwp <= 5'd0; fcnt <= 6'd0;
    end else begin
      if (dut_push || tb_push) begin
        fmem[fwp] <= dut_push ? wdata : tb_pdata;
        fwp <= fwp + 5'd1;
      end
      if (dut_pop || tb_pop) frp <= frp + 5'd1;
      fcnt <= fcnt + 6'((dut_push || tb_push) ? 1 : 0) - 6'((dut_pop || tb_pop) ? 1 : 0);
    end
    if (dut_push) begin push_log[npush[6:0]] <= wdata; npush <= npush + 1; end
    if (dut_pop) npop <= npop + 1;
    if (tx_valid && tx_ready) begin tx_log[ntx[6:0]] <= tx_data; ntx <= ntx + 1; end
    if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    tx_ready <= tx_stall_en ? ((ncyc % 3) != 0) : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [10:0] len_f, input logic [10:0] cnt_f);
    @(negedge clk); cfg_len_we = 1; cfg_len = len_f;
    @(negedge clk); cfg_len_we = 0; cfg_cnt_we = 1; cfg_cnt = cnt_f;
    @(negedge clk); cfg_cnt_we = 0;
  endtask

  task automatic go(input logic rd);
    @(negedge clk); start = 1; start_rd = rd;
    chk("R11 flush with start", {31'd0, flush}, 1);
    @(negedge clk); start = 0;
  endtask

  task automatic add_rx(input logic [7:0] b);
    rx_bytes[rx_tail[6:0]] = b;
    rx_tail++;
  endtask

  task automatic wait_done(input int target, input string req);
    for (int i = 0; i < 3000 && done_cnt < target; i++) @(negedge clk);
    chk(req, done_cnt, target);
  endtask

  task automatic t_reset;
    chk("R1 active", {31'd0, active}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 byte_left", byte_left, 1);
    chk("R1 blk_left", blk_left, 1);
    chk("R1 quiet", {28'd0, rx_ready, tx_valid, dut_push, dut_pop}, 0);
  endtask

  task automatic t_read_even;
    int p0 = npush;
    int d0 = done_cnt;
    cfg(11'd3, 11'd1);
    chk("R2 block length", byte_left, 4);
    chk("R2 block count", blk_left, 2);
    for (int i = 0; i < 8; i++) add_rx(8'h10 + 8'(i));
    go(1'b1);
    rx_lim = rx_tail - 4;
    idle(10);
    chk("R6 block decrement", blk_left, 1);
    chk("R6 byte reload", byte_left, 4);
    chk("R12 no tx in read", {31'd0, tx_valid}, 0);
    rx_lim = rx_tail;
    wait_done(d0 + 1, "R7 done count even");
    idle(3);
    chk("R3 push count", npush - p0, 4);
    chk("R3 word0", push_log[p0], 16'h1110);
    chk("R3 word1", push_log[p0+1], 16'h1312);
    chk("R3 word3", push_log[p0+3], 16'h1716);
    chk("R7 active cleared", {31'd0, active}, 0);
    chk("R7 blocks reloaded", blk_left, 2);
    chk("R7 single done pulse", done_cnt, d0 + 1);
  endtask

  task automatic t_read_odd;
    int p0 = npush;
    int d0 = done_cnt;
    cfg(11'd2, 11'd1);
    for (int i = 0; i < 6; i++) add_rx(8'hA0 + 8'(i));
    go(1'b1);
    rx_lim = rx_tail;
    wait_done(d0 + 1, "R7 done odd");
    idle(3);
    chk("R4 push count", npush - p0, 4);
    chk("R4 word0", push_log[p0], 16'hA1A0);
    chk("R4 odd tail", push_log[p0+1], 16'h00A2);
    chk("R4 next block fresh", push_log[p0+2], 16'hA4A3);
    chk("R4 odd tail 2", push_log[p0+3], 16'h00A5);
    chk("R11 fifo flushed then refilled", fcnt, 4);
  endtask

  task automatic t_write_odd;
    int q0 = ntx;
    int o0 = npop;
    int d0 = done_cnt;
    logic [15:0] words [0:3];
    words[0] = 16'hB1B0; words[1] = 16'hDEAD; words[2] = 16'hC3C2; words[3] = 16'hBEEF;
    cfg(11'd2, 11'd1);
    tx_stall_en = 1;
    go(1'b0);
    chk("R11 flush empties", fcnt, 0);
    idle(5);
    chk("R9 no tx while empty", {31'd0, tx_valid}, 0);
    chk("R9 no pop while empty", npop - o0, 0);
    chk("R12 no rx in write", {31'd0, rx_ready}, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); tb_push = 1; tb_pdata = words[i];
    end
    @(negedge clk); tb_push = 0;
    wait_done(d0 + 1, "R7 done write");
    idle(3);
    chk("R5 pop count", npop - o0, 4);
    chk("R5 tx count", ntx - q0, 6);
    chk("R5 low first", tx_log[q0], 8'hB0);
    chk("R5 high second", tx_log[q0+1], 8'hB1);
    chk("R4 odd tail write", tx_log[q0+2], 8'hAD);
    chk("R4 block2 fresh word", tx_log[q0+3], 8'hC2);
    chk("R5 block2 high", tx_log[q0+4], 8'hC3);
    chk("R4 final odd", tx_log[q0+5], 8'hEF);
    tx_stall_en = 0;
  endtask

  task automatic t_read_pause;
    int p0 = npush;
    int d0 = done_cnt;
    cfg(11'd9, 11'd0);
    afull_thr = 5'd1;
    for (int i = 0; i < 10; i++) add_rx(8'h30 + 8'(i));
    go(1'b1);
    rx_lim = rx_tail;
    idle(20);
    chk("R8 paused level", fcnt, 2);
    chk("R8 paused byte_left", byte_left, 6);
    chk("R8 ready low", {31'd0, rx_ready}, 0);
    @(negedge clk); tb_pop = 1;
    @(negedge clk); tb_pop = 0;
    idle(10);
    chk("R8 one word after pop", npush - p0, 3);
    chk("R8 byte_left after pop", byte_left, 4);
    afull_thr = 5'd31;
    wait_done(d0 + 1, "R7 done pause");
    chk("R8 total words", npush - p0, 5);
  endtask

  task automatic t_count_reload;
    int d0 = done_cnt;
    cfg(11'd4, 11'd2);
    go(1'b1);
    add_rx(8'h60); add_rx(8'h61);
    rx_lim = rx_tail;
    idle(6);
    chk("R10 before rewrite", byte_left, 3);
    @(negedge clk); cfg_cnt_we = 1; cfg_cnt = 11'd0;
    @(negedge clk); cfg_cnt_we = 0;
    chk("R10 byte reloaded", byte_left, 5);
    chk("R2 count rewritten", blk_left, 1);
    for (int i = 2; i < 7; i++) add_rx(8'h60 + 8'(i));
    rx_lim = rx_tail;
    wait_done(d0 + 1, "R10 done after rewrite");
  endtask

  task automatic t_len_one;
    int p0 = npush;
    int d0 = done_cnt;
    cfg(11'd0, 11'd2);
    add_rx(8'h5A); add_rx(8'h5B); add_rx(8'h5C);
    go(1'b1);
    rx_lim = rx_tail;
    wait_done(d0 + 1, "R4 done len one");
    chk("R4 len one words", npush - p0, 3);
    chk("R4 len one w0", push_log[p0], 16'h005A);
    chk("R4 len one w2", push_log[p0+2], 16'h005C);
  endtask

  task automatic t_restart_discard;
    int p0;
    int d0 = done_cnt;
    cfg(11'd3, 11'd0);
    add_rx(8'hEE);
    go(1'b1);
    rx_lim = rx_tail;
    idle(5);
    chk("R11 partial taken", byte_left, 3);
    cfg(11'd3, 11'd0);
    p0 = npush;
    for (int i = 1; i < 5; i++) add_rx(8'(i));
    go(1'b1);
    rx_lim = rx_tail;
    wait_done(d0 + 1, "R11 done after restart");
    chk("R11 restart words", npush - p0, 2);
    chk("R11 partial discarded", push_log[p0], 16'h0201);
    chk("R11 second word", push_log[p0+1], 16'h0403);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_len_we = 0; cfg_cnt_we = 0; cfg_len = '0; cfg_cnt = '0;
    start = 0; start_rd = 0; afull_thr = 5'd31; tb_push = 0; tb_pop = 0;
    tb_pdata = '0; tx_stall_en = 0; tx_ready = 1;
    idle(4);
    rst_n = 1;
    idle(4);
    t_reset();
    t_read_even();
    t_read_odd();
    t_write_odd();
    t_read_pause();
    t_count_reload();
    t_len_one();
    t_restart_discard();
    idle(5);
    finish_run();
  end

endmodule